// File: doc/BRIEF.md
# Paced DMA Burst Request Generator

This block sits between a pixel staging buffer and a DMA engine. It keeps its own count of the words held in the buffer, raising it for every word written in and lowering it by one burst whenever the DMA engine accepts a request. A request is offered once enough words for a whole burst are waiting and a programmable minimum spacing since the previous accepted request has passed. The spacing is given as a thermometer code: the number of set bits is the gap in cycles.

Accepted bursts are counted into blocks. The burst length and block size in use come from an active copy of the configuration ports. The copy is refreshed either when a block completes or when a frame ends, so the DMA engine never sees a size change in the middle of a block or a frame. Each refresh raises a one-cycle load event. The block also reports an almost-full flag against a programmable threshold. It flags an overrun when a word arrives while the buffer is full. Requests can be held off while frame information is being read.

Top module: `burst_pacer`

## Requirements
- R1: After reset, req_valid, fill_count, block_done, cfg_loaded and overrun are 0. The active burst length is 128 and the active block size is 8191.
- R2: req_valid is 1 exactly when enable is 1, fill_count is at least the active burst length, the gap has expired and requests are not masked (R4). It depends on the current inputs with no register delay.
- R3: The gap is the number of ones in cfg_gap_code, and a code of all zeros counts as 1. After an accepted request (req_valid and req_grant) in cycle t, req_valid stays 0 until cycle t+gap. A gap of 1 therefore allows back-to-back requests, and 0xFFFF spaces them 16 cycles apart.
- R4: While cfg_mask_on_read is 1 and frame_info_rd is 1, req_valid is 0. When cfg_mask_on_read is 0, frame_info_rd has no effect on req_valid.
- R5: One cycle after an accepted request, fill_count has dropped by the active burst length. If a word was also written in that cycle, it has risen by 1 as well. A req_grant without req_valid changes nothing.
- R6: The buffer is full when fill_count equals BUF_DEPTH (default 4096). A word written while full leaves fill_count unchanged, and overrun is 1 for one cycle in the next cycle.
- R7: almost_full is 1 exactly when fill_count is at least cfg_afull_thresh.
- R8: Every accepted request increments a burst counter. The request that brings the counter to the active block size completes a block. That request returns the counter to 0 and raises block_done for one cycle in the next cycle. An active block size of 0 behaves like 1. A frame_end pulse returns the counter to 0.
- R9: With cfg_upd_by_block at 1, the cfg_burst_len and cfg_block_size values present during a block-completing request become active in the next cycle. cfg_loaded is 1 in that same cycle. Between such loads, the active values do not change.
- R10: With cfg_upd_by_block at 0, the values present during a frame_end pulse become active in the next cycle, and cfg_loaded is 1 in that cycle. In this mode a completed block does not load the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows requests |
| wr_valid | input | 1 | One word written into the buffer this cycle |
| frame_end | input | 1 | Frame boundary pulse |
| frame_info_rd | input | 1 | Frame information is being read |
| cfg_burst_len | input | 12 | Pending words per burst |
| cfg_block_size | input | 13 | Pending bursts per block |
| cfg_gap_code | input | 16 | Thermometer-coded minimum request gap |
| cfg_upd_by_block | input | 1 | 1: load at block end, 0: load at frame end |
| cfg_mask_on_read | input | 1 | Suppress requests during frame_info_rd |
| cfg_afull_thresh | input | 14 | Almost-full threshold |
| req_grant | input | 1 | DMA engine accepts the offered request |
| req_valid | output | 1 | Burst request |
| act_burst_len | output | 12 | Burst length in use |
| act_block_size | output | 13 | Block size in use |
| fill_count | output | 14 | Words held in the buffer |
| almost_full | output | 1 | fill_count at or above threshold |
| block_done | output | 1 | Block-complete pulse |
| cfg_loaded | output | 1 | Configuration-load pulse |
| overrun | output | 1 | Write-while-full pulse |

## Verification
req_valid and almost_full are combinational on registered state, so they are due in the same cycle as the inputs that decide them. fill_count, the active settings, block_done, cfg_loaded and overrun change at the clock edge that follows the cycle causing them. The bench drives inputs one time unit after each rising edge. It steps a behavioural model of the block at each rising edge from the same inputs and compares every output at the falling edge, so each result is sampled in exactly the cycle it is due. A separate check measures the spacing between grants while the widest gap code is in force.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int DEF_BURST_W   = 12;
    localparam int DEF_BLOCK_W   = 13;
    localparam int DEF_FILL_W    = 14;
    localparam int DEF_GAP_BITS  = 16;
    localparam int DEF_BUF_DEPTH = 4096;
    localparam int RST_BURST_LEN = 128;
    localparam int RST_BLOCK_LEN = 8191;

    // Moment at which the pending burst and block settings are committed
    typedef enum logic {
        COMMIT_AT_FRAME = 1'b0,
        COMMIT_AT_BLOCK = 1'b1
    } commit_mode_e;
endpackage

// File: rtl/pacer_gap.sv
module pacer_gap #(
    parameter int GAP_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GAP_BITS-1:0] gap_code,
    input  logic                restart,
    output logic                expired
);
    localparam int CNT_W = $clog2(GAP_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] wait_cnt;
    } gap_state_t;

    gap_state_t       st_q, st_d;
    logic [CNT_W-1:0] ones;
    logic [CNT_W-1:0] span;

    // Population count of the thermometer code; an empty code counts as one cycle
    always_comb begin
        ones = '0;
        for (int i = 0; i < GAP_BITS; i++) begin
            ones = ones + CNT_W'(gap_code[i]);
        end
        span = (ones == '0) ? CNT_W'(1) : ones;
    end

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.wait_cnt = span - CNT_W'(1);
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.wait_cnt == '0);
endmodule

// File: rtl/pacer_fill.sv
module pacer_fill #(
    parameter int FILL_W    = 14,
    parameter int BURST_W   = 12,
    parameter int BUF_DEPTH = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               take,
    input  logic [BURST_W-1:0] take_len,
    output logic [FILL_W-1:0]  fill,
    output logic               overrun
);
    localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(BUF_DEPTH);

    typedef struct packed {
        logic [FILL_W-1:0] level;
        logic              ovr;
    } fill_state_t;

    fill_state_t st_q, st_d;
    logic        blocked;
    logic [FILL_W-1:0] sub;

    always_comb begin
        st_d    = st_q;
        blocked = wr_valid && (st_q.level >= FULL_LVL);
        sub     = take ? FILL_W'(take_len) : '0;
        st_d.ovr   = blocked;
        st_d.level = st_q.level + FILL_W'(wr_valid && !blocked) - sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill    = st_q.level;
    assign overrun = st_q.ovr;
endmodule

// File: rtl/pacer_blocks.sv
module pacer_blocks
    import pacer_pkg::*;
#(
    parameter int BURST_W   = 12,
    parameter int BLOCK_W   = 13,
    parameter int RST_BURST = 128,
    parameter int RST_BLOCK = 8191
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               frame_end,
    input  logic               upd_by_block,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic [BLOCK_W-1:0] cfg_block,
    output logic [BURST_W-1:0] act_burst,
    output logic [BLOCK_W-1:0] act_block,
    output logic               block_done,
    output logic               cfg_loaded
);
    typedef struct packed {
        logic [BLOCK_W-1:0] bcnt;
        logic [BURST_W-1:0] burst;
        logic [BLOCK_W-1:0] block;
        logic               done;
        logic               loaded;
    } blk_state_t;

    blk_state_t       st_q, st_d;
    logic [BLOCK_W:0] next_cnt;
    logic             wrap;
    logic             commit;
    commit_mode_e     mode;

    always_comb begin
        st_d     = st_q;
        mode     = commit_mode_e'(upd_by_block);
        next_cnt = {1'b0, st_q.bcnt} + (BLOCK_W + 1)'(1);
        // A size of zero wraps on every burst, same as a size of one
        wrap     = take && (next_cnt >= {1'b0, st_q.block});
        commit   = (mode == COMMIT_AT_BLOCK) ? wrap : frame_end;

        if (frame_end) begin
            st_d.bcnt = '0;
        end else if (take) begin
            st_d.bcnt = wrap ? '0 : next_cnt[BLOCK_W-1:0];
        end
        st_d.done   = wrap;
        st_d.loaded = commit;
        if (commit) begin
            st_d.burst = cfg_burst;
            st_d.block = cfg_block;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bcnt   <= '0;
            st_q.burst  <= BURST_W'(RST_BURST);
            st_q.block  <= BLOCK_W'(RST_BLOCK);
            st_q.done   <= 1'b0;
            st_q.loaded <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_burst  = st_q.burst;
    assign act_block  = st_q.block;
    assign block_done = st_q.done;
    assign cfg_loaded = st_q.loaded;
endmodule

// File: rtl/burst_pacer.sv
module burst_pacer
    import pacer_pkg::*;
#(
    parameter int BURST_W   = DEF_BURST_W,
    parameter int BLOCK_W   = DEF_BLOCK_W,
    parameter int FILL_W    = DEF_FILL_W,
    parameter int GAP_BITS  = DEF_GAP_BITS,
    parameter int BUF_DEPTH = DEF_BUF_DEPTH,
    parameter int RST_BURST = RST_BURST_LEN,
    parameter int RST_BLOCK = RST_BLOCK_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr_valid,
    input  logic                frame_end,
    input  logic                frame_info_rd,
    input  logic [BURST_W-1:0]  cfg_burst_len,
    input  logic [BLOCK_W-1:0]  cfg_block_size,
    input  logic [GAP_BITS-1:0] cfg_gap_code,
    input  logic                cfg_upd_by_block,
    input  logic                cfg_mask_on_read,
    input  logic [FILL_W-1:0]   cfg_afull_thresh,
    input  logic                req_grant,
    output logic                req_valid,
    output logic [BURST_W-1:0]  act_burst_len,
    output logic [BLOCK_W-1:0]  act_block_size,
    output logic [FILL_W-1:0]   fill_count,
    output logic                almost_full,
    output logic                block_done,
    output logic                cfg_loaded,
    output logic                overrun
);
    logic gap_open;
    logic masked;
    logic take;

    always_comb begin
        masked    = cfg_mask_on_read && frame_info_rd;
        req_valid = enable && gap_open && !masked
                    && (fill_count >= FILL_W'(act_burst_len));
        take      = req_valid && req_grant;
        almost_full = (fill_count >= cfg_afull_thresh);
    end

    pacer_gap #(
        .GAP_BITS (GAP_BITS)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .gap_code (cfg_gap_code),
        .restart  (take),
        .expired  (gap_open)
    );

    pacer_fill #(
        .FILL_W    (FILL_W),
        .BURST_W   (BURST_W),
        .BUF_DEPTH (BUF_DEPTH)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .take     (take),
        .take_len (act_burst_len),
        .fill     (fill_count),
        .overrun  (overrun)
    );

    pacer_blocks #(
        .BURST_W   (BURST_W),
        .BLOCK_W   (BLOCK_W),
        .RST_BURST (RST_BURST),
        .RST_BLOCK (RST_BLOCK)
    ) u_blocks (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .frame_end    (frame_end),
        .upd_by_block (cfg_upd_by_block),
        .cfg_burst    (cfg_burst_len),
        .cfg_block    (cfg_block_size),
        .act_burst    (act_burst_len),
        .act_block    (act_block_size),
        .block_done   (block_done),
        .cfg_loaded   (cfg_loaded)
    );
endmodule

// File: rtl/burst_pacer_chk.sv
module burst_pacer_chk #(
    parameter int BURST_W   = 12,
    parameter int BLOCK_W   = 13,
    parameter int FILL_W    = 14,
    parameter int GAP_BITS  = 16,
    parameter int BUF_DEPTH = 4096
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic                frame_info_rd,
    input logic [GAP_BITS-1:0] cfg_gap_code,
    input logic                cfg_mask_on_read,
    input logic                req_grant,
    input logic                req_valid,
    input logic [BURST_W-1:0]  act_burst_len,
    input logic [BLOCK_W-1:0]  act_block_size,
    input logic [FILL_W-1:0]   fill_count,
    input logic                block_done,
    input logic                cfg_loaded,
    input logic                overrun
);
    localparam logic [FILL_W-1:0] FULL_LVL = FILL_W'(BUF_DEPTH);

    p_req_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (fill_count >= FILL_W'(act_burst_len)));

    p_widest_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grant && (cfg_gap_code == '1)) |=> !req_valid);

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask_on_read && frame_info_rd) |-> !req_valid);

    p_grant_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_grant && !wr_valid) |=>
        (fill_count == $past(fill_count) - FILL_W'($past(act_burst_len))));

    p_full_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (fill_count == FULL_LVL) && !(req_valid && req_grant)) |=>
        (overrun && $stable(fill_count)));

    p_done_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_done) |-> $past(req_valid && req_grant));

    p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loaded |-> ($stable(act_burst_len) && $stable(act_block_size)));
endmodule

bind burst_pacer burst_pacer_chk #(
    .BURST_W   (BURST_W),
    .BLOCK_W   (BLOCK_W),
    .FILL_W    (FILL_W),
    .GAP_BITS  (GAP_BITS),
    .BUF_DEPTH (BUF_DEPTH)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_valid         (wr_valid),
    .frame_info_rd    (frame_info_rd),
    .cfg_gap_code     (cfg_gap_code),
    .cfg_mask_on_read (cfg_mask_on_read),
    .req_grant        (req_grant),
    .req_valid        (req_valid),
    .act_burst_len    (act_burst_len),
    .act_block_size   (act_block_size),
    .fill_count       (fill_count),
    .block_done       (block_done),
    .cfg_loaded       (cfg_loaded),
    .overrun          (overrun)
);

// File: tb/burst_pacer_tb.sv
module burst_pacer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_valid = 1'b0;
    logic        frame_end = 1'b0;
    logic        frame_info_rd = 1'b0;
    logic [11:0] cfg_burst_len = 12'd4;
    logic [12:0] cfg_block_size = 13'd3;
    logic [15:0] cfg_gap_code = 16'h0001;
    logic        cfg_upd_by_block = 1'b0;
    logic        cfg_mask_on_read = 1'b0;
    logic [13:0] cfg_afull_thresh = 14'd20;
    logic        req_grant = 1'b0;
    logic        req_valid;
    logic [11:0] act_burst_len;
    logic [12:0] act_block_size;
    logic [13:0] fill_count;
    logic        almost_full, block_done, cfg_loaded, overrun;

    burst_pacer u_dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit running = 1'b0;
    bit in_gap16 = 1'b0;
    bit in_mask = 1'b0;
    int cyc = 0;
    int last_grant = -1;

    // Behavioural reference state
    int m_fill = 0, m_gap = 0, m_bcnt = 0, m_burst = 128, m_block = 8191;
    int m_bd = 0, m_cl = 0, m_ovr = 0;
    int n_bd = 0, n_cl = 0, n_ovr = 0, n_take = 0;
    int ones;
    bit g, wrap, commit, ovr;

    function automatic bit exp_valid();
        return enable && (m_gap == 0) && (m_fill >= m_burst)
               && !(cfg_mask_on_read && frame_info_rd);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_fill = 0; m_gap = 0; m_bcnt = 0; m_burst = 128; m_block = 8191;
            m_bd = 0; m_cl = 0; m_ovr = 0;
        end else begin
            g = req_grant && exp_valid();
            ones = 0;
            for (int i = 0; i < 16; i++) ones += cfg_gap_code[i];
            if (ones == 0) ones = 1;
            wrap   = g && (m_bcnt + 1 >= m_block);
            commit = cfg_upd_by_block ? wrap : frame_end;
            ovr    = wr_valid && (m_fill >= DEPTH);
            m_fill = m_fill + ((wr_valid && !ovr) ? 1 : 0) - (g ? m_burst : 0);
            if (g) m_gap = ones - 1;
            else if (m_gap > 0) m_gap--;
            if (frame_end) m_bcnt = 0;
            else if (g) m_bcnt = wrap ? 0 : m_bcnt + 1;
            m_bd = wrap; m_cl = commit; m_ovr = ovr;
            if (commit) begin
                m_burst = cfg_burst_len;
                m_block = cfg_block_size;
            end
            n_bd += wrap; n_cl += commit; n_ovr += ovr; n_take += g;
        end
    end

    always @(negedge clk) begin
        if (running) begin
            chk("R2/R3/R4 req_valid", req_valid, exp_valid());
            chk("R5 fill_count", fill_count, m_fill);
            chk("R7 almost_full", almost_full, m_fill >= cfg_afull_thresh);
            chk("R6 overrun", overrun, m_ovr);
            chk("R8 block_done", block_done, m_bd);
            chk("R9/R10 cfg_loaded", cfg_loaded, m_cl);
            chk("R9 act_burst_len", act_burst_len, m_burst);
            chk("R9 act_block_size", act_block_size, m_block);
            if (in_mask) chk("R4 masked req_valid", req_valid, 0);
            if (req_valid && req_grant) begin
                if (in_gap16 && last_grant >= 0) chk("R3 spacing at 0xFFFF", cyc - last_grant, 16);
                last_grant = cyc;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1 req_valid", req_valid, 0);
        chk("R1 fill_count", fill_count, 0);
        chk("R1 act_burst_len", act_burst_len, 128);
        chk("R1 act_block_size", act_block_size, 8191);
        chk("R1 pulses", block_done + cfg_loaded + overrun, 0);
        running = 1'b1;
        step(1);

        // R10: frame-end load of burst 4, block 3
        frame_end = 1'b1; step(1); frame_end = 1'b0;
        enable = 1'b1; wr_valid = 1'b1; req_grant = 1'b1;
        step(60);
        // R3: widest gap
        cfg_gap_code = 16'hFFFF; last_grant = -1; in_gap16 = 1'b1;
        step(100);
        in_gap16 = 1'b0;
        cfg_gap_code = 16'h0000; step(30);
        cfg_gap_code = 16'h0007; step(20);
        req_grant = 1'b0; step(5); req_grant = 1'b1; step(10);
        // R4: mask on, then frame_info_rd alone
        frame_info_rd = 1'b1; cfg_mask_on_read = 1'b1; in_mask = 1'b1;
        step(15);
        in_mask = 1'b0; cfg_mask_on_read = 1'b0; step(15);
        frame_info_rd = 1'b0;
        // R10: a frame end with new values mid-stream; blocks do not load
        cfg_burst_len = 12'd3; cfg_block_size = 13'd2;
        frame_end = 1'b1; step(1); frame_end = 1'b0; step(30);
        // R9: block-end loads, including size 0
        cfg_upd_by_block = 1'b1; cfg_burst_len = 12'd2; cfg_block_size = 13'd0;
        step(20);
        cfg_block_size = 13'd5; cfg_burst_len = 12'd1; step(40);
        frame_end = 1'b1; step(1); frame_end = 1'b0; step(10);
        cfg_burst_len = 12'd2;
        // disabled period
        enable = 1'b0; step(20); enable = 1'b1;
        // R6/R7: fill to full without grants
        req_grant = 1'b0; cfg_afull_thresh = 14'd4000; cfg_gap_code = 16'h0001;
        step(4200);
        // drain, with a write alongside
        req_grant = 1'b1; step(10); wr_valid = 1'b0;
        step(2200);
        cfg_afull_thresh = 14'd0; step(5);

        chk("R8 block_done seen", n_bd > 0, 1);
        chk("R9/R10 loads seen", n_cl > 2, 1);
        chk("R6 overrun seen", n_ovr > 0, 1);
        chk("R5 grants seen", n_take > 100, 1);
        running = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule